// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer with Peripheral Keepalive

This block is a down-counting watchdog driven by a slow timebase tick (nominally 1 kHz) and programmed over a simple indexed register bus. Software selects whether the counter decrements once per second or once per minute. It starts the watchdog by writing a nonzero count into the two count bytes and stops it by writing a total count of zero. When the count runs out, the counter halts at zero and a sticky status flag is set. Depending on configuration, a keyboard-reset output pulses for a fixed number of ticks and a power-good gating output is held.

Software does not kick the watchdog through a register of its own. Instead, ordinary peripheral bus traffic serves as the keepalive: either a read strobe aimed at the game-port address or a write strobe aimed at the infrared-receiver data register, each enabled by its own control bit. The counter reloads a short, fixed number of ticks after such an event. The counter width can be 8 or 16 bits. An 8-bit counter ignores the high count byte completely.

Top module: `tmr_watchdog`

## Requirements
- R1: After reset, all four registers (index 0x71 control, 0x72 configuration, 0x73 count low byte, 0x74 count high byte) read 0x00, the counter is stopped, and `kbd_rst_o` and `pwr_gate_o` are low.
- R2: The configuration register stores and reads back all 8 bits, and its bits 3:0 appear on `irq_route_o`. The control register reads back bit 7 (infrared keepalive enable) and bit 4 (game-port keepalive enable), bit 0 as the status flag, and zero in every other bit.
- R3: A write to either count byte loads the counter with {high, low} and restarts the prescaler, including while the counter is already running. If the loaded value is zero, the watchdog stops and never expires.
- R4: With configuration bit 7 set (seconds), a count of N expires exactly N×TICKS_PER_SEC ticks after the load.
- R5: With configuration bit 7 clear (minutes), a count of N expires after N×TICKS_PER_SEC×SEC_PER_MIN ticks. On expiry, control bit 0 sets and the counter stays stopped until a new nonzero count is written.
- R6: If configuration bit 6 is set at expiry, `kbd_rst_o` is high for exactly RST_TICKS ticks starting at the expiry. If that bit is clear, `kbd_rst_o` stays low.
- R7: `pwr_gate_o` is high exactly while the status flag is set and configuration bit 4 is set.
- R8: The status flag is sticky. A control write with bit 0 clear clears it, and a control write with bit 0 set leaves it unchanged. An expiry in the same cycle as a clearing write wins.
- R9: If control bit 4 is set, a pulse on `gp_rd_strobe` reloads a running counter from the count registers on the KICK_DELAY-th tick after the pulse, and the prescaler restarts at that point.
- R10: If control bit 7 is set, a pulse on `ir_wr_strobe` reloads the counter in the same way. A strobe whose enable bit is clear has no effect on the expiry time.
- R11: With CNT_W = 8, writes to the high count byte are ignored: they neither load the counter nor change the readback, which stays 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k | input | 1 | One-cycle timebase pulse |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the indexed register |
| gp_rd_strobe | input | 1 | Game-port read event |
| ir_wr_strobe | input | 1 | Infrared data register write event |
| kbd_rst_o | output | 1 | Keyboard reset request |
| pwr_gate_o | output | 1 | Power-good gating request |
| irq_route_o | output | 4 | Interrupt routing selection |

## Verification
The bench builds the 16-bit counter with 4 ticks per second, 3 seconds per minute, a 4-tick reset pulse and a 2-tick keepalive delay. With these values, a minute-unit expiry comes after 12 ticks, so each expiry edge can be checked one tick before and at the exact tick. It also builds an 8-bit instance on the same bus, so the case where the high byte is ignored can be compared against the 16-bit counter.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;

    localparam logic [7:0] IDX_CTRL   = 8'h71;
    localparam logic [7:0] IDX_CFG    = 8'h72;
    localparam logic [7:0] IDX_CNT_LO = 8'h73;
    localparam logic [7:0] IDX_CNT_HI = 8'h74;

    // control register enables (bits 7 and 4 of index 0x71)
    typedef struct packed {
        logic ir_en;
        logic gp_en;
    } ctrl_t;

    // configuration register, packed in bit order 7..0
    typedef struct packed {
        logic       unit_sec;
        logic       kbd_en;
        logic       spare;
        logic       pwr_en;
        logic [3:0] irq_sel;
    } cfg_t;

    function automatic int unsigned presc_limit(input logic unit_sec,
                                                input int unsigned tps,
                                                input int unsigned spm);
        return unit_sec ? tps : tps * spm;
    endfunction

    function automatic logic [7:0] ctrl_image(input ctrl_t c, input logic st);
        return {c.ir_en, 2'b00, c.gp_en, 3'b000, st};
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import tmr_wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    input  logic             expire,
    output ctrl_t            ctrl,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] reload_val,
    output logic             load,
    output logic             status,
    output logic [7:0]       rdata
);
    logic [7:0]  lo_q;
    logic [7:0]  hi_q;
    logic [15:0] full;
    logic        wr_lo, wr_hi;

    assign wr_lo = we && (idx == IDX_CNT_LO);

    generate
        if (CNT_W > 8) begin : g_hi
            assign wr_hi = we && (idx == IDX_CNT_HI);
            always_ff @(posedge clk) begin
                if (rst)        hi_q <= '0;
                else if (wr_hi) hi_q <= wdata;
            end
        end else begin : g_no_hi
            assign wr_hi = 1'b0;
            assign hi_q  = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            ctrl   <= '0;
            cfg    <= '0;
            status <= 1'b0;
            load   <= 1'b0;
        end else begin
            load <= wr_lo || wr_hi;
            if (wr_lo) lo_q <= wdata;
            if (we && idx == IDX_CFG) cfg <= cfg_t'(wdata);
            if (we && idx == IDX_CTRL) ctrl <= '{ir_en: wdata[7], gp_en: wdata[4]};
            if (expire)                                     status <= 1'b1;
            else if (we && idx == IDX_CTRL && !wdata[0])    status <= 1'b0;
        end
    end

    assign full       = {hi_q, lo_q};
    assign reload_val = full[CNT_W-1:0];

    always_comb begin
        unique case (idx)
            IDX_CTRL:   rdata = ctrl_image(ctrl, status);
            IDX_CFG:    rdata = cfg;
            IDX_CNT_LO: rdata = lo_q;
            IDX_CNT_HI: rdata = hi_q;
            default:    rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import tmr_wdt_pkg::*;
#(
    parameter int TPS = 1000,
    parameter int SPM = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic restart,
    input  logic unit_sec,
    output logic unit_pulse
);
    localparam int PRE_W = $clog2(TPS * SPM + 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim_m1;
    logic             at_end;

    assign lim_m1 = PRE_W'(presc_limit(unit_sec, TPS, SPM) - 1);
    assign at_end = (pre_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) pre_q <= '0;
        else if (tick)              pre_q <= at_end ? '0 : pre_q + 1'b1;
    end

    assign unit_pulse = run && tick && at_end && !restart;
endmodule

// File: rtl/wdt_kick.sv
module wdt_kick #(
    parameter int KD = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic event_i,
    output logic fire
);
    localparam int DW = $clog2(KD + 1);

    logic [DW-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst)                        dly_q <= '0;
        else if (event_i)               dly_q <= DW'(KD);
        else if (tick && dly_q != '0)   dly_q <= dly_q - 1'b1;
    end

    assign fire = tick && !event_i && (dly_q == DW'(1));
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             reload,
    input  logic [CNT_W-1:0] value,
    input  logic             unit_pulse,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    assign expire = unit_pulse && running && !load && !reload && (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else if (load) begin
            count   <= value;
            running <= (value != '0);
        end else if (reload && running) begin
            count <= value;
        end else if (unit_pulse && running) begin
            count <= count - 1'b1;
            if (count == CNT_W'(1)) running <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_rstpulse.sv
module wdt_rstpulse #(
    parameter int RST_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int RW = $clog2(RST_TICKS + 1);

    logic [RW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                        left_q <= '0;
        else if (start)                 left_q <= RW'(RST_TICKS);
        else if (tick && left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog
    import tmr_wdt_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int TICKS_PER_SEC = 1000,
    parameter int SEC_PER_MIN   = 60,
    parameter int RST_TICKS     = 16,
    parameter int KICK_DELAY    = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1k,
    input  logic       reg_we,
    input  logic [7:0] reg_idx,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       gp_rd_strobe,
    input  logic       ir_wr_strobe,
    output logic       kbd_rst_o,
    output logic       pwr_gate_o,
    output logic [3:0] irq_route_o
);
    ctrl_t            ctrl_w;
    cfg_t             cfg_w;
    logic [CNT_W-1:0] val_w;
    logic [CNT_W-1:0] cnt_w;
    logic             load_w, status_w, run_w, expire_w;
    logic             unit_w, fire_w, kick_ev_w, restart_w, kbd_en_w;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
        .expire(expire_w), .ctrl(ctrl_w), .cfg(cfg_w), .reload_val(val_w),
        .load(load_w), .status(status_w), .rdata(reg_rdata)
    );

    assign kick_ev_w = (ctrl_w.gp_en && gp_rd_strobe) || (ctrl_w.ir_en && ir_wr_strobe);

    wdt_kick #(.KD(KICK_DELAY)) u_kick (
        .clk(clk), .rst(rst), .tick(tick_1k), .event_i(kick_ev_w), .fire(fire_w)
    );

    assign restart_w = load_w || (fire_w && run_w);

    wdt_prescale #(.TPS(TICKS_PER_SEC), .SPM(SEC_PER_MIN)) u_pre (
        .clk(clk), .rst(rst), .tick(tick_1k), .run(run_w), .restart(restart_w),
        .unit_sec(cfg_w.unit_sec), .unit_pulse(unit_w)
    );

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load_w), .reload(fire_w), .value(val_w),
        .unit_pulse(unit_w), .running(run_w), .count(cnt_w), .expire(expire_w)
    );

    wdt_rstpulse #(.RST_TICKS(RST_TICKS)) u_rstp (
        .clk(clk), .rst(rst), .start(expire_w && cfg_w.kbd_en), .tick(tick_1k),
        .active(kbd_rst_o)
    );

    assign kbd_en_w    = cfg_w.kbd_en;
    assign pwr_gate_o  = status_w && cfg_w.pwr_en;
    assign irq_route_o = cfg_w.irq_sel;
endmodule

// File: rtl/tmr_watchdog_chk.sv
module tmr_watchdog_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             status,
    input logic             kbd_rst,
    input logic             pwr_gate,
    input logic             kbd_en,
    input logic             load
);
    // R3: a running counter never holds zero
    assert_run_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        running |-> (count != '0));

    // R5: the flag rises together with the counter halting at zero
    assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> (count == '0 && !running));

    // R5: a stopped counter changes only through a count write
    assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (rst)
        (!running && !load) |=> $stable(count));

    // R6: reset request only after an expiry with the enable set
    assert_kbd_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(kbd_rst) |-> (status && $past(kbd_en)));

    // R7: power gating only while the flag is set
    assert_pwr_gate_R7: assert property (@(posedge clk) disable iff (rst)
        pwr_gate |-> status);
endmodule

bind tmr_watchdog tmr_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .running(run_w), .count(cnt_w), .status(status_w),
    .kbd_rst(kbd_rst_o), .pwr_gate(pwr_gate_o), .kbd_en(kbd_en_w), .load(load_w)
);

// File: tb/tmr_watchdog_tb.sv
module tmr_watchdog_tb;
    localparam logic [7:0] CTRL = 8'h71, CFG = 8'h72, LO = 8'h73, HI = 8'h74;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [7:0] idx = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       gp = 1'b0;
    logic       ir = 1'b0;
    logic [7:0] rdata, rdata8;
    logic       kbd, kbd8, pwr, pwr8;
    logic [3:0] irq, irq8;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tmr_watchdog #(.CNT_W(16), .TICKS_PER_SEC(4), .SEC_PER_MIN(3),
                   .RST_TICKS(4), .KICK_DELAY(2)) u_dut (
        .clk(clk), .rst(rst), .tick_1k(tick), .reg_we(we), .reg_idx(idx),
        .reg_wdata(wdata), .reg_rdata(rdata), .gp_rd_strobe(gp), .ir_wr_strobe(ir),
        .kbd_rst_o(kbd), .pwr_gate_o(pwr), .irq_route_o(irq)
    );

    tmr_watchdog #(.CNT_W(8), .TICKS_PER_SEC(4), .SEC_PER_MIN(3),
                   .RST_TICKS(4), .KICK_DELAY(2)) u_dut8 (
        .clk(clk), .rst(rst), .tick_1k(tick), .reg_we(we), .reg_idx(idx),
        .reg_wdata(wdata), .reg_rdata(rdata8), .gp_rd_strobe(gp), .ir_wr_strobe(ir),
        .kbd_rst_o(kbd8), .pwr_gate_o(pwr8), .irq_route_o(irq8)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] d);
        @(negedge clk); we = 1'b1; idx = i; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] i, output logic [7:0] v, output logic [7:0] v8);
        @(negedge clk); idx = i; #1; v = rdata; v8 = rdata8;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_gp();
        @(negedge clk); gp = 1'b1;
        @(negedge clk); gp = 1'b0;
    endtask

    task automatic pulse_ir();
        @(negedge clk); ir = 1'b1;
        @(negedge clk); ir = 1'b0;
    endtask

    function automatic logic [15:0] st_bit(input logic [7:0] v);
        return {15'd0, v[0]};
    endfunction

    task automatic halt_all();
        wr(HI, 8'h00); wr(LO, 8'h00); wr(CTRL, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v, v8;
        rd(CTRL, v, v8); chk("R1 ctrl", v, 8'h00);
        rd(CFG, v, v8);  chk("R1 cfg", v, 8'h00);
        rd(LO, v, v8);   chk("R1 lo", v, 8'h00);
        rd(HI, v, v8);   chk("R1 hi", v, 8'h00);
        chk("R1 kbd/pwr", {kbd, pwr}, 2'b00);
    endtask

    task automatic t_regs();
        logic [7:0] v, v8;
        wr(CFG, 8'hA5);
        rd(CFG, v, v8); chk("R2 cfg readback", v, 8'hA5);
        chk("R2 irq route", irq, 4'h5);
        wr(CTRL, 8'hFF);
        rd(CTRL, v, v8); chk("R2 R8 ctrl image, bit0 not settable", v, 8'h90);
        wr(CTRL, 8'h00);
        wr(LO, 8'h34); wr(HI, 8'h12);
        rd(LO, v, v8); chk("R3 lo readback", v, 8'h34);
        rd(HI, v, v8); chk("R3 hi readback", v, 8'h12);
        halt_all();
    endtask

    task automatic t_seconds();
        logic [7:0] v, v8;
        wr(CFG, 8'hC0);
        wr(LO, 8'h03);
        ticks(11);
        rd(CTRL, v, v8); chk("R4 no expiry at 11 ticks", st_bit(v), 1'b0);
        chk("R6 kbd low before expiry", kbd, 1'b0);
        ticks(1);
        rd(CTRL, v, v8); chk("R4 expiry at 12 ticks", st_bit(v), 1'b1);
        chk("R6 kbd high at expiry", kbd, 1'b1);
        ticks(3);
        chk("R6 kbd held 3 ticks later", kbd, 1'b1);
        ticks(1);
        chk("R6 kbd released after 4 ticks", kbd, 1'b0);
        wr(CTRL, 8'h00);
        ticks(20);
        rd(CTRL, v, v8); chk("R5 stays stopped after expiry", st_bit(v), 1'b0);
        halt_all();
    endtask

    task automatic t_minutes();
        logic [7:0] v, v8;
        wr(CFG, 8'h10);
        wr(LO, 8'h01);
        ticks(11);
        rd(CTRL, v, v8); chk("R5 no expiry at 11 ticks", st_bit(v), 1'b0);
        chk("R7 pwr low before expiry", pwr, 1'b0);
        ticks(1);
        rd(CTRL, v, v8); chk("R5 minute expiry at 12 ticks", st_bit(v), 1'b1);
        chk("R7 pwr high on expiry", pwr, 1'b1);
        chk("R6 kbd stays low with enable clear", kbd, 1'b0);
        wr(CTRL, 8'h01);
        rd(CTRL, v, v8); chk("R8 write with bit0 set keeps flag", st_bit(v), 1'b1);
        wr(CTRL, 8'h00);
        rd(CTRL, v, v8); chk("R8 clearing write", st_bit(v), 1'b0);
        chk("R7 pwr follows flag", pwr, 1'b0);
        halt_all();
    endtask

    task automatic t_stop_reload();
        logic [7:0] v, v8;
        wr(CFG, 8'h80);
        wr(LO, 8'h02);
        ticks(5);
        wr(LO, 8'h00);
        ticks(20);
        rd(CTRL, v, v8); chk("R3 zero count stops", st_bit(v), 1'b0);
        wr(LO, 8'h02);
        ticks(5);
        wr(LO, 8'h02);
        ticks(7);
        rd(CTRL, v, v8); chk("R3 rewrite restarts count", st_bit(v), 1'b0);
        ticks(1);
        rd(CTRL, v, v8); chk("R3 expiry 8 ticks after rewrite", st_bit(v), 1'b1);
        halt_all();
    endtask

    task automatic t_gameport();
        logic [7:0] v, v8;
        wr(CFG, 8'h80);
        wr(CTRL, 8'h10);
        wr(LO, 8'h02);
        ticks(5);
        pulse_gp();
        ticks(2);
        ticks(7);
        rd(CTRL, v, v8); chk("R9 game-port keepalive delays expiry", st_bit(v), 1'b0);
        ticks(1);
        rd(CTRL, v, v8); chk("R9 expiry 8 ticks after reload", st_bit(v), 1'b1);
        halt_all();
    endtask

    task automatic t_infrared();
        logic [7:0] v, v8;
        wr(CFG, 8'h80);
        wr(CTRL, 8'h10);
        wr(LO, 8'h02);
        ticks(5);
        pulse_ir();
        ticks(2);
        rd(CTRL, v, v8); chk("R10 disabled source no effect, not yet", st_bit(v), 1'b0);
        ticks(1);
        rd(CTRL, v, v8); chk("R10 disabled source no effect, expired", st_bit(v), 1'b1);
        wr(CTRL, 8'h80);
        wr(LO, 8'h02);
        ticks(5);
        pulse_ir();
        ticks(9);
        rd(CTRL, v, v8); chk("R10 infrared keepalive delays expiry", st_bit(v), 1'b0);
        ticks(1);
        rd(CTRL, v, v8); chk("R10 expiry after infrared reload", st_bit(v), 1'b1);
        halt_all();
    endtask

    task automatic t_narrow();
        logic [7:0] v, v8;
        wr(CFG, 8'h80);
        wr(HI, 8'h05);
        rd(HI, v, v8); chk("R11 high byte reads zero in 8-bit", v8, 8'h00);
        chk("R11 high byte stored in 16-bit", v, 8'h05);
        wr(LO, 8'h01);
        ticks(3);
        rd(CTRL, v, v8); chk("R11 8-bit no expiry at 3 ticks", st_bit(v8), 1'b0);
        ticks(1);
        rd(CTRL, v, v8); chk("R11 8-bit expiry ignores high byte", st_bit(v8), 1'b1);
        chk("R11 16-bit still counting", st_bit(v), 1'b0);
        halt_all();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_seconds();
        t_minutes();
        t_stop_reload();
        t_gameport();
        t_infrared();
        t_narrow();
        repeat (4) @(negedge clk);
        summary();
    end
endmodule